// File: doc/BRIEF.md
# Display-memory write command decoder

This block sits behind a serial receiver that has already framed bytes and marked packet boundaries. It reads a stream of command bytes and turns it into write requests for an on-screen character memory. Each request names a row, a column, a plane (character code or attribute) and a 9-bit data word. A packet always opens with a row byte. After that, the packet may switch between three framings:
- a per-location framing, where every data byte is preceded by a fresh row byte;
- a same-row framing, where every data byte is preceded by only a column byte;
- a streaming framing, where data bytes follow back to back and the address advances by itself.

Once a packet enters the streaming framing, it stays there until the packet ends.

The byte input and the write output are both valid/ready streams. The output holds one request in a register. A byte is taken only when that register is empty or is being emptied in the same cycle, so `in_ready` equals `!wr_valid || wr_ready`. While `wr_valid` is high and `wr_ready` is low, the request on the output stays unchanged and no byte is consumed. The packet start and end pulses and the error flag are plain single-cycle signals and are never held off.

Top module: `osd_wr_decoder`

## Requirements
- R1: After reset, `wr_valid` and `seq_err` are 0, `in_ready` is 1, and the decoder waits for a row byte.
- R2: A row byte has bit 7 = 1. Its bit 5 selects the plane: 1 is the attribute plane and 0 is the character-code plane. In the attribute plane the row is bits 4..0. In the code plane the row is bits 3..0, bit 4 is ignored, and the reported row is below 16.
- R3: Where a column byte may appear, a byte with bit 7 = 0 is a column byte, with the column in bits 4..0. Its bit 6 = 0 means exactly one data byte follows. Bit 6 = 1 enters streaming. Where a column is expected, a second row byte replaces the first without an error.
- R4: In the code plane, bit 5 of the column byte becomes data bit 8 and the data byte gives bits 7..0. In the attribute plane, data bit 8 is 0 and column bit 5 is ignored.
- R5: After a non-streaming data byte, the next byte is a new row byte if its bit 7 = 1. Otherwise it is a column byte that keeps the current row and plane.
- R6: In streaming, every byte is data, including bytes with bit 7 = 1. Data bit 8 stays as latched from the column byte. After each data byte the column advances by one. After column NUM_COLS-1 it wraps to column 0 of the next row, and after row NUM_ROWS-1 it wraps to row 0.
- R7: `pkt_start` sends the decoder back to waiting for a row byte, and a byte in the same cycle is treated as the first byte of the new packet. `pkt_end` does the same after the byte of its own cycle has been handled.
- R8: A byte with bit 7 = 0 that arrives while a row byte is expected is dropped: no write is made, and `seq_err` is high for exactly the cycle after it was accepted.
- R9: Each accepted data byte yields exactly one request. `wr_valid` rises in the cycle after acceptance, and while `wr_ready` is low the row, column, plane and data stay stable.
- R10: While a request is stalled, `in_ready` is 0 and an offered byte is not consumed. In the cycle the request is taken, a new byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte offered |
| in_ready | output | 1 | Decoder takes the byte this cycle |
| in_byte | input | 8 | Command byte |
| pkt_start | input | 1 | Packet begins (single-cycle pulse) |
| pkt_end | input | 1 | Packet ends (single-cycle pulse) |
| wr_valid | output | 1 | Write request present |
| wr_ready | input | 1 | Memory takes the request |
| wr_attr | output | 1 | 1 = attribute plane, 0 = character-code plane |
| wr_row | output | ROW_W | Row of the write |
| wr_col | output | COL_W | Column of the write |
| wr_data | output | 9 | Data word |
| seq_err | output | 1 | Out-of-sequence byte dropped (single-cycle pulse) |

## Verification
The bench goes after the streaming wrap at the last column and at the last row. A decoder that got this wrong would run into the unused column 30 or spill past row 14. It also feeds stream bytes with bit 7 set: a decoder that reclassified them as row bytes would leave streaming and lose data. Further cases are:
- the font bit carried from the column byte, which would be lost or leak into the attribute plane;
- a packet start in the middle of a stream, which must abort the stream;
- a data byte arriving with the end pulse;
- a stalled request, where a weak design would drop or duplicate a byte, or let the address move under a pending write.

// File: rtl/osdw_pkg.sv
package osdw_pkg;
  localparam int BYTE_W    = 8;
  localparam int MARK_BIT  = 7;  // 1 = row byte where a header is expected
  localparam int MODE_BIT  = 6;  // column byte: 1 = streaming
  localparam int PLANE_BIT = 5;  // row byte: 1 = attribute plane
  localparam int HI_BIT    = 5;  // column byte: font code bit 8

  typedef enum logic [2:0] {
    ST_ROW,     // waiting for a row byte
    ST_COL,     // row seen, waiting for a column byte
    ST_DATA,    // single data byte expected
    ST_NEXT,    // after a single data byte: row or column
    ST_STREAM   // every byte is data
  } osdw_state_e;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_ROW,
    ACT_COL,
    ACT_DATA
  } osdw_act_e;
endpackage

// File: rtl/osdw_seq.sv
module osdw_seq
  import osdw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      acc,
  input  logic      mark,
  input  logic      mode,
  input  logic      pkt_start,
  input  logic      pkt_end,
  output osdw_act_e act_o,
  output logic      stream_o,
  output logic      bad_o
);
  osdw_state_e st_q, cur, nxt;

  // A start pulse takes effect before the byte of the same cycle.
  assign cur      = pkt_start ? ST_ROW : st_q;
  assign stream_o = (cur == ST_STREAM);

  always_comb begin
    act_o = ACT_NONE;
    bad_o = 1'b0;
    nxt   = cur;
    if (acc) begin
      unique case (cur)
        ST_ROW: begin
          if (mark) begin
            act_o = ACT_ROW;
            nxt   = ST_COL;
          end else begin
            bad_o = 1'b1;
          end
        end
        ST_COL, ST_NEXT: begin
          if (mark) begin
            act_o = ACT_ROW;
            nxt   = ST_COL;
          end else begin
            act_o = ACT_COL;
            nxt   = mode ? ST_STREAM : ST_DATA;
          end
        end
        ST_DATA: begin
          act_o = ACT_DATA;
          nxt   = ST_NEXT;
        end
        ST_STREAM: begin
          act_o = ACT_DATA;
        end
        default: nxt = ST_ROW;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= ST_ROW;
    else if (pkt_end) st_q <= ST_ROW;
    else              st_q <= nxt;
  end
endmodule

// File: rtl/osdw_addr.sv
module osdw_addr
  import osdw_pkg::*;
#(
  parameter int ROW_W    = 5,
  parameter int COL_W    = 5,
  parameter int NUM_ROWS = 15,
  parameter int NUM_COLS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  osdw_act_e         act,
  input  logic              stream,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              attr_o,
  output logic [BYTE_W:0]   data_o
);
  localparam int              CODE_ROW_W = ROW_W - 1;
  localparam logic [ROW_W-1:0] ROW_LAST  = ROW_W'(NUM_ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST  = COL_W'(NUM_COLS - 1);

  logic [ROW_W-1:0] row_q, row_new;
  logic [COL_W-1:0] col_q;
  logic             attr_q, hi_q;

  assign row_new = byte_i[PLANE_BIT] ? byte_i[ROW_W-1:0]
                                     : {1'b0, byte_i[CODE_ROW_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      attr_q <= 1'b0;
      hi_q   <= 1'b0;
    end else begin
      unique case (act)
        ACT_ROW: begin
          attr_q <= byte_i[PLANE_BIT];
          row_q  <= row_new;
        end
        ACT_COL: begin
          col_q <= byte_i[COL_W-1:0];
          hi_q  <= byte_i[HI_BIT] & ~attr_q;
        end
        ACT_DATA: begin
          if (stream) begin
            if (col_q >= COL_LAST) begin
              col_q <= '0;
              row_q <= (row_q >= ROW_LAST) ? '0 : row_q + ROW_W'(1);
            end else begin
              col_q <= col_q + COL_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign row_o  = row_q;
  assign col_o  = col_q;
  assign attr_o = attr_q;
  assign data_o = {hi_q & ~attr_q, byte_i};
endmodule

// File: rtl/osdw_outreg.sv
module osdw_outreg #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] dout,
  output logic         space_o
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign space_o = ~vld_q | ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (load) begin
      vld_q <= 1'b1;
      dat_q <= din;
    end else if (ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign valid_o = vld_q;
  assign dout    = dat_q;
endmodule

// File: rtl/osd_wr_decoder.sv
module osd_wr_decoder
  import osdw_pkg::*;
#(
  parameter int ROW_W    = 5,
  parameter int COL_W    = 5,
  parameter int NUM_ROWS = 15,
  parameter int NUM_COLS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              pkt_start,
  input  logic              pkt_end,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_attr,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [BYTE_W:0]   wr_data,
  output logic              seq_err
);
  localparam int DATA_W = BYTE_W + 1;
  localparam int REQ_W  = 1 + ROW_W + COL_W + DATA_W;

  logic             acc, stream, bad, err_q, space;
  osdw_act_e        act;
  logic [ROW_W-1:0] a_row;
  logic [COL_W-1:0] a_col;
  logic             a_attr;
  logic [DATA_W-1:0] a_data;
  logic [REQ_W-1:0] req_d, req_q;

  assign in_ready = space;
  assign acc      = in_valid & space;

  osdw_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .mark      (in_byte[MARK_BIT]),
    .mode      (in_byte[MODE_BIT]),
    .pkt_start (pkt_start),
    .pkt_end   (pkt_end),
    .act_o     (act),
    .stream_o  (stream),
    .bad_o     (bad)
  );

  osdw_addr #(
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .NUM_ROWS (NUM_ROWS),
    .NUM_COLS (NUM_COLS)
  ) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (act),
    .stream (stream),
    .byte_i (in_byte),
    .row_o  (a_row),
    .col_o  (a_col),
    .attr_o (a_attr),
    .data_o (a_data)
  );

  assign req_d = {a_attr, a_row, a_col, a_data};

  osdw_outreg #(.W(REQ_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (act == ACT_DATA),
    .din     (req_d),
    .ready_i (wr_ready),
    .valid_o (wr_valid),
    .dout    (req_q),
    .space_o (space)
  );

  assign {wr_attr, wr_row, wr_col, wr_data} = req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= bad;
  end
  assign seq_err = err_q;
endmodule

// File: rtl/osd_wr_decoder_chk.sv
module osd_wr_decoder_chk #(
  parameter int ROW_W = 5,
  parameter int COL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_mark,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             wr_attr,
  input logic [ROW_W-1:0] wr_row,
  input logic [COL_W-1:0] wr_col,
  input logic [8:0]       wr_data,
  input logic             seq_err
);
  // R2: code-plane rows never use the top row bit
  assert_code_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_attr |-> !wr_row[ROW_W-1]);

  // R4: attribute-plane words never carry a font bit 8
  assert_attr_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_attr |-> !wr_data[8]);

  // R8: a dropped byte never produces a write
  assert_err_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> !wr_valid);

  // R8: an error flag follows an accepted byte without the row mark
  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> $past(in_valid && in_ready && !in_mark));

  // R9: a new request comes only from an accepted byte
  assert_write_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(in_valid && in_ready));

  // R9: a stalled request holds still
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable({wr_attr, wr_row, wr_col, wr_data}));

  // R10: no byte is taken while a request is stalled
  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |-> !in_ready);
endmodule

bind osd_wr_decoder osd_wr_decoder_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_mark  (in_byte[7]),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_attr  (wr_attr),
  .wr_row   (wr_row),
  .wr_col   (wr_col),
  .wr_data  (wr_data),
  .seq_err  (seq_err)
);

// File: tb/osd_wr_decoder_bench.sv
module osd_wr_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_ready;
  logic [7:0] in_byte = 8'h00;
  logic       pkt_start = 1'b0, pkt_end = 1'b0;
  logic       wr_valid, wr_ready = 1'b1, wr_attr;
  logic [4:0] wr_row, wr_col;
  logic [8:0] wr_data;
  logic       seq_err;

  always #4 clk = ~clk;

  osd_wr_decoder u_osd_wr_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .pkt_start(pkt_start), .pkt_end(pkt_end),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_attr(wr_attr),
    .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data), .seq_err(seq_err)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // {start, end, byte, exp_wr, exp_err, exp_attr, exp_row, exp_col, exp_data}
  localparam int NV = 35;
  localparam logic [31:0] VEC [NV] = '{
    {1'b1,1'b0,8'h83,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R2 code row 3
    {1'b0,1'b0,8'h25,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R3 col 5, hi=1
    {1'b0,1'b0,8'h41,1'b1,1'b0,1'b0,5'd3 ,5'd5 ,9'h141}, // R4 font bit 8
    {1'b0,1'b0,8'h07,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R5 column only
    {1'b0,1'b0,8'hAA,1'b1,1'b0,1'b0,5'd3 ,5'd7 ,9'h0AA}, // R5 same row
    {1'b0,1'b0,8'h9C,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R2 bit4 ignored
    {1'b0,1'b0,8'h02,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R3
    {1'b0,1'b0,8'hFF,1'b1,1'b0,1'b0,5'd12,5'd2 ,9'h0FF}, // R5 new row
    {1'b0,1'b0,8'hA4,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R2 attr row 4
    {1'b0,1'b0,8'h3D,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R4 bit5 ignored
    {1'b0,1'b0,8'h55,1'b1,1'b0,1'b1,5'd4 ,5'd29,9'h055}, // R4 attr data
    {1'b0,1'b0,8'h7C,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R3 stream col 28
    {1'b0,1'b0,8'h11,1'b1,1'b0,1'b1,5'd4 ,5'd28,9'h011}, // R6
    {1'b0,1'b0,8'h80,1'b1,1'b0,1'b1,5'd4 ,5'd29,9'h080}, // R6 bit7 is data
    {1'b0,1'b0,8'h92,1'b1,1'b0,1'b1,5'd5 ,5'd0 ,9'h092}, // R6 col wrap
    {1'b1,1'b0,8'h8E,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R7 code row 14
    {1'b0,1'b0,8'h7D,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R6 stream col 29
    {1'b0,1'b0,8'h01,1'b1,1'b0,1'b0,5'd14,5'd29,9'h101}, // R6 bit8 held
    {1'b0,1'b0,8'hC3,1'b1,1'b0,1'b0,5'd0 ,5'd0 ,9'h1C3}, // R6 row wrap
    {1'b1,1'b0,8'h10,1'b0,1'b1,1'b0,5'd0 ,5'd0 ,9'h000}, // R8 no row byte
    {1'b0,1'b0,8'h05,1'b0,1'b1,1'b0,5'd0 ,5'd0 ,9'h000}, // R8 again
    {1'b0,1'b0,8'h81,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R7 recover
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R3
    {1'b0,1'b1,8'h33,1'b1,1'b0,1'b0,5'd1 ,5'd0 ,9'h033}, // R7 end with data
    {1'b0,1'b0,8'h04,1'b0,1'b1,1'b0,5'd0 ,5'd0 ,9'h000}, // R7 after end
    {1'b0,1'b0,8'h82,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R2
    {1'b0,1'b0,8'h43,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R3 stream
    {1'b1,1'b0,8'h44,1'b0,1'b1,1'b0,5'd0 ,5'd0 ,9'h000}, // R7 start aborts
    {1'b0,1'b0,8'hA0,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R2 attr row 0
    {1'b0,1'b0,8'h40,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R3
    {1'b0,1'b0,8'h66,1'b1,1'b0,1'b1,5'd0 ,5'd0 ,9'h066}, // R6
    {1'b1,1'b0,8'h85,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R3
    {1'b0,1'b0,8'h86,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R3 row replaced
    {1'b0,1'b0,8'h01,1'b0,1'b0,1'b0,5'd0 ,5'd0 ,9'h000}, // R3
    {1'b0,1'b0,8'h22,1'b1,1'b0,1'b0,5'd6 ,5'd1 ,9'h022}  // R3
  };

  task automatic drive(input logic s, input logic e, input logic [7:0] b);
    @(negedge clk);
    pkt_start = s; pkt_end = e; in_byte = b; in_valid = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0; pkt_end = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(wr_valid == 1'b0, "R1", "wr_valid", wr_valid, 0);
    chk(seq_err == 1'b0, "R1", "seq_err", seq_err, 0);
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    drive(1'b0, 1'b0, 8'h12);
    chk(seq_err == 1'b1 && wr_valid == 1'b0, "R1", "wait-for-row err", seq_err, 1);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      drive(v[31], v[30], v[29:22]);
      chk(wr_valid == v[21], $sformatf("vec%0d", i), "wr_valid", wr_valid, v[21]);
      chk(seq_err == v[20], $sformatf("vec%0d", i), "seq_err", seq_err, v[20]);
      if (v[21])
        chk({wr_attr, wr_row, wr_col, wr_data} == v[19:0], $sformatf("vec%0d", i),
            "request", {wr_attr, wr_row, wr_col, wr_data}, v[19:0]);
      @(negedge clk);
      chk(wr_valid == 1'b0 && seq_err == 1'b0, "R9", "single pulse", wr_valid, 0);
    end

    // R9 / R10 back-pressure
    drive(1'b1, 1'b0, 8'h81);
    drive(1'b0, 1'b0, 8'h40);
    wr_ready = 1'b0;
    drive(1'b0, 1'b0, 8'h11);
    chk(wr_valid && {wr_row, wr_col, wr_data} == {5'd1, 5'd0, 9'h011}, "R9",
        "stalled write", {wr_row, wr_col, wr_data}, {5'd1, 5'd0, 9'h011});
    in_byte = 8'h22; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R10", "in_ready stalled", in_ready, 0);
      chk(wr_valid && {wr_col, wr_data} == {5'd0, 9'h011}, "R9", "hold",
          {wr_col, wr_data}, {5'd0, 9'h011});
    end
    wr_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(wr_valid && {wr_row, wr_col, wr_data} == {5'd1, 5'd1, 9'h022}, "R10",
        "byte taken on release", {wr_row, wr_col, wr_data}, {5'd1, 5'd1, 9'h022});
    @(negedge clk);
    chk(wr_valid == 1'b0, "R10", "no duplicate", wr_valid, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule